// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the per-function state of a message-signalled interrupt scheme with a small number of vectors. The state is a table of message entries, one per vector, a read-only array of pending bits, and two control bits: enable and a function-wide mask. Software reaches all of it through a 32-bit register port with one-cycle read latency. The device side raises interrupt requests by vector index. Each accepted request either becomes a message-write request on a valid/ready output, carrying the entry's 64-bit address and 32-bit data, or stays recorded as pending while its vector is masked.

A vector is masked when its own mask bit is set, or when the function-wide mask is in force. The function-wide mask is in force while enable is clear or mask-all is set. A pending vector is released automatically as soon as it becomes unmasked. The unmask can come from a per-vector control write or from a control write that lifts the function-wide mask. Released vectors go out one message per handshake, lowest index first. A control write that sets enable also produces a one-cycle pulse that tells the surrounding logic to drop its legacy wired interrupt.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, enable and mask-all read 0, every table word reads 0 except the vector-control word, which reads 1 (mask set), every pending bit reads 0, and msg_valid is 0.
- R2: The register address is {region[1:0], vector, word[1:0]}. Region 01 is the table, and its entry words are 0 = address low, 1 = address high, 2 = data, 3 = vector control. Only bit 0 (the mask) of the vector-control word is stored. Reads return data on the cycle after reg_sel. Table accesses to a vector at or above NUM_VEC are dropped, and such reads return 0.
- R3: Region 00, word 0, is message control. Bit 15 is enable, bit 14 is mask-all, and bits 10:0 read NUM_VEC-1 and ignore writes. All other bits read 0.
- R4: A request to a masked vector sets its pending bit and emits no message. Pending word k of region 10 holds the bits of vectors 32k to 32k+31, so vector v is bit v mod 8 of pending byte v div 8.
- R5: A request to an unmasked vector emits exactly one message that carries that entry's address, data and index.
- R6: A pending vector that becomes unmasked, by a per-vector mask clear or by lifting the function-wide mask, emits one message. Its pending bit clears when that message is accepted.
- R7: Several released vectors go out in ascending index order, one per accepted handshake. A message holds its address, data and index stable while msg_ready is low.
- R8: Requests with an index at or above NUM_VEC, or for a vector whose vec_used bit is 0, are ignored. Clearing a vec_used bit clears that vector's pending bit.
- R9: Writes to the pending region have no effect.
- R10: A control write with bit 15 set pulses intx_clr high for the next cycle. A control write with bit 15 clear does not pulse it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Word address {region, vector, word} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_valid | input | 1 | Device interrupt request strobe |
| irq_vec | input | IW | Requested vector index (one bit wider than needed) |
| vec_used | input | NUM_VEC | Per-vector in-use flags from the device |
| msg_valid | output | 1 | Message-write request valid |
| msg_ready | input | 1 | Message-write request accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | VIW | Vector index of the message |
| intx_clr | output | 1 | One-cycle pulse: deassert legacy interrupt |

## Verification
The bench builds the block with NUM_VEC = 6, which is not a power of two. With that value, table indices 6 and 7 still decode into the table region and must be dropped. Request indices 6 to 15 fit the request port and must also be ignored. The table-size field reads 5. Six vectors are enough to hold two and three pending vectors at once, which brings the ascending release order and the idle cycle after each handshake within reach. One of the six is left marked as unused.

// File: rtl/msixc_pkg.sv
package msixc_pkg;
  localparam int CTL_EN_BIT   = 15;
  localparam int CTL_MALL_BIT = 14;
  localparam int SIZE_W       = 11;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'b00,
    REG_TABLE = 2'b01,
    REG_PEND  = 2'b10,
    REG_VOID  = 2'b11
  } region_e;

  typedef enum logic [1:0] {
    EW_ADDR_LO = 2'd0,
    EW_ADDR_HI = 2'd1,
    EW_DATA    = 2'd2,
    EW_VCTL    = 2'd3
  } entry_word_e;

  // pending array rounded up to a multiple of 64 bits, counted in 32-bit words
  function automatic int pend_words(input int n);
    return ((n + 63) / 64) * 2;
  endfunction
endpackage

// File: rtl/msixc_table.sv
module msixc_table #(
  parameter int NUM_VEC = 8,
  parameter int VIW     = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [VIW-1:0]     wr_vec,
  input  logic [1:0]         wr_word,
  input  logic [31:0]        wr_data,
  input  logic [VIW-1:0]     rd_vec,
  input  logic [1:0]         rd_word,
  output logic [31:0]        rd_data,
  input  logic [VIW-1:0]     sel_vec,
  output logic [63:0]        sel_addr,
  output logic [31:0]        sel_data,
  output logic [NUM_VEC-1:0] vmask
);
  import msixc_pkg::*;

  logic [31:0] alo [NUM_VEC];
  logic [31:0] ahi [NUM_VEC];
  logic [31:0] dat [NUM_VEC];
  logic [NUM_VEC-1:0] msk;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        alo[i] <= '0;
        ahi[i] <= '0;
        dat[i] <= '0;
      end
      msk <= '1;
    end else if (wr_en) begin
      case (entry_word_e'(wr_word))
        EW_ADDR_LO: alo[wr_vec] <= wr_data;
        EW_ADDR_HI: ahi[wr_vec] <= wr_data;
        EW_DATA:    dat[wr_vec] <= wr_data;
        EW_VCTL:    msk[wr_vec] <= wr_data[0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (entry_word_e'(rd_word))
      EW_ADDR_LO: rd_data = alo[rd_vec];
      EW_ADDR_HI: rd_data = ahi[rd_vec];
      EW_DATA:    rd_data = dat[rd_vec];
      default:    rd_data = {31'b0, msk[rd_vec]};
    endcase
  end

  assign sel_addr = {ahi[sel_vec], alo[sel_vec]};
  assign sel_data = dat[sel_vec];
  assign vmask    = msk;
endmodule

// File: rtl/msixc_pend.sv
module msixc_pend #(
  parameter int NUM_VEC = 8,
  parameter int VIW     = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [VIW-1:0]     set_vec,
  input  logic [NUM_VEC-1:0] used,
  input  logic [NUM_VEC-1:0] masked,
  input  logic               msg_ready,
  input  logic [63:0]        pick_addr,
  input  logic [31:0]        pick_data,
  output logic [VIW-1:0]     pick_vec,
  output logic [NUM_VEC-1:0] pend,
  output logic               msg_valid,
  output logic [VIW-1:0]     msg_vec,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  logic [NUM_VEC-1:0] pend_q, pend_d, elig;
  logic any_elig, accept;

  assign accept = msg_valid && msg_ready;

  // lowest eligible index wins
  always_comb begin
    elig     = pend_q & ~masked;
    any_elig = |elig;
    pick_vec = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (elig[i]) pick_vec = VIW'(i);
  end

  always_comb begin
    pend_d = pend_q;
    if (accept) pend_d[msg_vec] = 1'b0;
    if (set_en) pend_d[set_vec] = 1'b1;
    pend_d = pend_d & used;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      msg_valid <= 1'b0;
      msg_vec   <= '0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      pend_q <= pend_d;
      if (accept) begin
        msg_valid <= 1'b0;
      end else if (!msg_valid && any_elig) begin
        msg_valid <= 1'b1;
        msg_vec   <= pick_vec;
        msg_addr  <= pick_addr;
        msg_data  <= pick_data;
      end
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl #(
  parameter  int NUM_VEC    = 8,
  localparam int VIW        = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int IW         = VIW + 1,
  localparam int TW         = VIW + 2,
  localparam int AW         = TW + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               irq_valid,
  input  logic [IW-1:0]      irq_vec,
  input  logic [NUM_VEC-1:0] vec_used,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  output logic [VIW-1:0]     msg_vec,
  output logic               intx_clr
);
  import msixc_pkg::*;

  localparam int PEND_WORDS = pend_words(NUM_VEC);
  localparam int PWW        = $clog2(PEND_WORDS);
  localparam int PADW       = PEND_WORDS * 32;

  logic en_q, mall_q, intx_q, fmask;
  logic [31:0] rdata_q, rd_mux, tbl_rd;
  logic [NUM_VEC-1:0] vmask, masked, pend;
  logic [VIW-1:0] t_vec, pick_vec;
  logic [1:0] t_word;
  logic [TW-1:0] low_addr;
  logic [PADW-1:0] pend_pad;
  logic [63:0] pick_addr;
  logic [31:0] pick_data;
  logic t_inrange, p_inrange, ctrl_hit, wr_acc, ctrl_wr, tbl_wr, req_ok;
  region_e rgn;

  assign rgn       = region_e'(reg_addr[AW-1 -: 2]);
  assign low_addr  = reg_addr[TW-1:0];
  assign t_vec     = low_addr[TW-1:2];
  assign t_word    = low_addr[1:0];
  assign t_inrange = {1'b0, t_vec} < IW'(NUM_VEC);
  assign p_inrange = low_addr < TW'(PEND_WORDS);
  assign ctrl_hit  = (rgn == REG_CTRL) && (low_addr == '0);

  assign wr_acc  = reg_sel && reg_wr;
  assign ctrl_wr = wr_acc && ctrl_hit;
  assign tbl_wr  = wr_acc && (rgn == REG_TABLE) && t_inrange;

  assign fmask  = !en_q || mall_q;
  assign masked = vmask | {NUM_VEC{fmask}};
  assign req_ok = irq_valid && (irq_vec < IW'(NUM_VEC)) && vec_used[irq_vec[VIW-1:0]];

  msixc_table #(.NUM_VEC(NUM_VEC), .VIW(VIW)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(tbl_wr), .wr_vec(t_vec), .wr_word(t_word), .wr_data(reg_wdata),
    .rd_vec(t_vec), .rd_word(t_word), .rd_data(tbl_rd),
    .sel_vec(pick_vec), .sel_addr(pick_addr), .sel_data(pick_data),
    .vmask(vmask)
  );

  msixc_pend #(.NUM_VEC(NUM_VEC), .VIW(VIW)) u_pend (
    .clk(clk), .rst(rst),
    .set_en(req_ok), .set_vec(irq_vec[VIW-1:0]), .used(vec_used),
    .masked(masked), .msg_ready(msg_ready),
    .pick_addr(pick_addr), .pick_data(pick_data), .pick_vec(pick_vec),
    .pend(pend), .msg_valid(msg_valid), .msg_vec(msg_vec),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  assign pend_pad = PADW'(pend);

  always_comb begin
    rd_mux = '0;
    case (rgn)
      REG_CTRL: if (ctrl_hit)
        rd_mux = {16'b0, en_q, mall_q, 3'b0, SIZE_W'(NUM_VEC - 1)};
      REG_TABLE: if (t_inrange) rd_mux = tbl_rd;
      REG_PEND:  if (p_inrange) rd_mux = pend_pad[32*low_addr[PWW-1:0] +: 32];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      mall_q  <= 1'b0;
      intx_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      intx_q <= ctrl_wr && reg_wdata[CTL_EN_BIT];
      if (ctrl_wr) begin
        en_q   <= reg_wdata[CTL_EN_BIT];
        mall_q <= reg_wdata[CTL_MALL_BIT];
      end
      if (reg_sel && !reg_wr) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata = rdata_q;
  assign intx_clr  = intx_q;
endmodule

// File: rtl/msixc_check.sv
module msixc_check #(
  parameter int NUM_VEC = 8,
  parameter int VIW     = 3,
  parameter int AW      = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic [VIW-1:0]     msg_vec,
  input logic               fmask,
  input logic [NUM_VEC-1:0] vmask,
  input logic               reg_sel,
  input logic               reg_wr,
  input logic [AW-1:0]      reg_addr,
  input logic               reg_wdata_en,
  input logic               intx_clr
);
  logic               prev_fmask;
  logic [NUM_VEC-1:0] prev_vmask;
  logic               ctrl_en_wr;

  always_ff @(posedge clk) begin
    prev_fmask <= fmask;
    prev_vmask <= vmask;
  end

  assign ctrl_en_wr = reg_sel && reg_wr && (reg_addr == '0) && reg_wdata_en;

  // R1: reset leaves no message and the function masked
  p_reset_masked_r1: assert property (@(posedge clk)
    rst |=> (!msg_valid && fmask));

  // R6: a message only starts for a vector that was unmasked
  p_launch_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> (!prev_fmask && !prev_vmask[msg_vec]));

  // R7: a stalled message holds its content
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) &&
                                   $stable(msg_data) && $stable(msg_vec)));

  // R7: one message per handshake, idle cycle after acceptance
  p_gap_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |=> !msg_valid);

  // R10: enable write pulses the legacy deassert
  p_intx_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    ctrl_en_wr |=> intx_clr);

  p_intx_only_on_write_r10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en_wr |=> !intx_clr);
endmodule

bind msix_vec_ctrl msixc_check #(.NUM_VEC(NUM_VEC), .VIW(VIW), .AW(AW)) u_check (
  .clk(clk), .rst(rst),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec),
  .fmask(fmask), .vmask(vmask),
  .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata_en(reg_wdata[msixc_pkg::CTL_EN_BIT]),
  .intx_clr(intx_clr)
);

// File: tb/msix_vec_ctrl_bench.sv
`timescale 1ns/1ps
module msix_vec_ctrl_bench;
  localparam int NV = 6;
  localparam int VW = 3;
  localparam int IW = 4;
  localparam int AW = 7;
  localparam logic [AW-1:0] CTRL_A = 7'h00;
  localparam logic [AW-1:0] PEND_A = 7'h40;

  // {addr, wdata, expected readback}
  localparam logic [70:0] VT [10] = '{
    {7'h00, 32'h0000_4000, 32'h0000_4005},
    {7'h00, 32'h0000_3FFF, 32'h0000_0005},
    {7'h00, 32'h0000_7FFF, 32'h0000_4005},
    {7'h00, 32'h0000_0000, 32'h0000_0005},
    {7'h23, 32'hFFFF_FFFE, 32'h0000_0000},
    {7'h23, 32'h0000_0003, 32'h0000_0001},
    {7'h38, 32'h1234_5678, 32'h0000_0000},
    {7'h3E, 32'hCAFE_F00D, 32'h0000_0000},
    {7'h35, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {7'h40, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_valid = 1'b0;
  logic [IW-1:0] irq_vec = '0;
  logic [NV-1:0] vec_used = '1;
  logic msg_valid, msg_ready = 1'b0, intx_clr;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic [VW-1:0] msg_vec;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  msix_vec_ctrl #(.NUM_VEC(NV)) u_msix_vec_ctrl (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .vec_used(vec_used),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_vec(msg_vec), .intx_clr(intx_clr)
  );

  always #2 clk = ~clk;

  function automatic logic [AW-1:0] ta(input int v, input int w);
    return {2'b01, 3'(v), 2'(w)};
  endfunction
  function automatic logic [31:0] palo(input int v); return 32'hFEE0_0000 | (v << 4); endfunction
  function automatic logic [31:0] pahi(input int v); return 32'h0000_00A0 + v; endfunction
  function automatic logic [31:0] pdat(input int v); return 32'h0000_4100 + v; endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    rd(a, d);
    check(tag, 64'(d), 64'(e));
  endtask

  task automatic req(input int v);
    irq_valid = 1'b1; irq_vec = IW'(v);
    @(posedge clk); @(negedge clk);
    irq_valid = 1'b0;
  endtask

  task automatic no_msg(input int n, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (msg_valid) seen = 1'b1;
      @(negedge clk);
    end
    if (msg_valid) seen = 1'b1;
    check(tag, 64'(seen), 64'd0);
  endtask

  task automatic get_msg(input int v, input int hold, input string tag);
    logic [63:0] a0; logic [31:0] d0; logic [VW-1:0] v0;
    for (int w = 0; w < 12 && !msg_valid; w++) @(negedge clk);
    check({tag, " valid"}, 64'(msg_valid), 64'd1);
    if (hold > 0) begin
      a0 = msg_addr; d0 = msg_data; v0 = msg_vec;
      repeat (hold) @(negedge clk);
      check({tag, " stable"}, 64'({msg_valid, msg_addr == a0, msg_data == d0, msg_vec == v0}), 64'hF);
    end
    check({tag, " vec"}, 64'(msg_vec), 64'(v));
    check({tag, " addr"}, msg_addr, {pahi(v), palo(v)});
    check({tag, " data"}, 64'(msg_data), 64'(pdat(v)));
    msg_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state, R3 size field
    check("R1 msg_valid after reset", 64'(msg_valid), 64'd0);
    rd_chk(CTRL_A, 32'h0000_0005, "R1 R3 control after reset");
    rd_chk(ta(0, 3), 32'h1, "R1 mask set after reset");
    rd_chk(ta(4, 2), 32'h0, "R1 data zero after reset");
    rd_chk(PEND_A, 32'h0, "R1 pending zero after reset");

    // vector table walk: R2 R3 R9
    foreach (VT[i]) begin
      wr(VT[i][70:64], VT[i][63:32]);
      rd(VT[i][70:64], rv);
      check($sformatf("R2 R3 R9 vector %0d", i), 64'(rv), 64'(VT[i][31:0]));
    end

    for (int v = 0; v < NV; v++) begin
      wr(ta(v, 0), palo(v));
      wr(ta(v, 1), pahi(v));
      wr(ta(v, 2), pdat(v));
    end
    rd_chk(ta(2, 0), palo(2), "R2 entry address low");
    rd_chk(ta(2, 2), pdat(2), "R2 entry data");
    vec_used = 6'b101111;

    // R4: disabled function masks everything
    req(1);
    no_msg(4, "R4 disabled no message");
    rd_chk(PEND_A, 32'h02, "R4 pending bit 1");

    // R10 pulse on enable write, R4 mask-all
    wr(CTRL_A, 32'h0000_C000);
    check("R10 intx pulse", 64'(intx_clr), 64'd1);
    @(negedge clk);
    check("R10 intx single cycle", 64'(intx_clr), 64'd0);
    no_msg(3, "R4 mask-all no message");
    wr(PEND_A, 32'h0);
    rd_chk(PEND_A, 32'h02, "R9 pending write ignored");

    for (int v = 0; v < 4; v++) wr(ta(v, 3), 32'h0);
    no_msg(3, "R4 mask-all holds");
    req(3);
    rd_chk(PEND_A, 32'h0A, "R4 pending bits 1 and 3");

    // R6 R7: lifting mask-all releases in ascending order
    wr(CTRL_A, 32'h0000_8000);
    get_msg(1, 3, "R6 R7 release first");
    get_msg(3, 0, "R7 release second");
    no_msg(3, "R6 no extra release");
    rd_chk(PEND_A, 32'h0, "R6 pending cleared");

    // R5 direct message
    req(0);
    get_msg(0, 0, "R5 unmasked request");
    no_msg(4, "R5 single message");

    // R6 per-vector unmask
    req(5);
    no_msg(3, "R4 own mask no message");
    rd_chk(PEND_A, 32'h20, "R4 pending bit 5");
    wr(ta(5, 3), 32'h0);
    get_msg(5, 0, "R6 per-vector unmask");

    // R8 ignored requests
    req(4);
    no_msg(3, "R8 unused vector");
    rd_chk(PEND_A, 32'h0, "R8 unused not pending");
    req(6);
    req(9);
    no_msg(3, "R8 index beyond range");
    rd_chk(PEND_A, 32'h0, "R8 beyond range not pending");
    wr(ta(2, 3), 32'h1);
    req(2);
    rd_chk(PEND_A, 32'h04, "R8 masked vector 2 pending");
    vec_used = 6'b101011;
    @(negedge clk);
    rd_chk(PEND_A, 32'h0, "R8 unuse clears pending");
    vec_used = 6'b101111;
    wr(ta(2, 3), 32'h0);
    no_msg(3, "R8 nothing left to release");

    // R7 three-way ordering
    wr(CTRL_A, 32'h0000_C000);
    req(3); req(0); req(2);
    rd_chk(PEND_A, 32'h0D, "R7 three pending");
    wr(CTRL_A, 32'h0000_8000);
    get_msg(0, 1, "R7 order first");
    get_msg(2, 0, "R7 order second");
    get_msg(3, 0, "R7 order third");

    // R10 no pulse when enable is written clear
    wr(CTRL_A, 32'h0000_0000);
    check("R10 no pulse on disable", 64'(intx_clr), 64'd0);
    req(1);
    no_msg(3, "R4 disable masks again");
    rd_chk(PEND_A, 32'h02, "R4 pending while disabled");

    // R1 reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd_chk(CTRL_A, 32'h0000_0005, "R1 control after second reset");
    rd_chk(ta(1, 0), 32'h0, "R1 table cleared");
    rd_chk(ta(3, 3), 32'h1, "R1 mask restored");
    rd_chk(PEND_A, 32'h0, "R1 pending cleared");

    summary();
    $finish;
  end
endmodule